// File: doc/BRIEF.md
# Byte-wise I2C slave receiver with coded status

This block lets a processor receive bytes as a 7-bit-addressed I2C slave. It samples the bus clock and data lines through a short synchronizer and finds START and STOP conditions. It shifts in each byte most significant bit first. Once a byte has arrived, the acknowledge level that software chose earlier goes back on the bus. It drives both bus lines only through open-drain enables, so a high on an enable pulls that line low.

After every bus event that matters, the block pauses the transfer. It puts a five-bit state code into a read-only status register and raises an interrupt flag. While that flag is set and the bus clock is low, the block holds the clock low. Software reads the code and the received byte, then writes a clear bit to release the bus. A general-call enable bit in the address register lets the slave also answer the all-zero address.

Register offsets on `bus_sel`: 0 = control (write 1 to set, reads back flags), 1 = clear (write 1 to clear, reads 0), 2 = status, 3 = data, 4 = own address.

Top module: `i2c_srx_top`

## Requirements
- R1: After reset the status register reads 0xF8, the control register reads 0x00, the data register reads 0x00, and neither open-drain enable is active.
- R2: Bits 2:0 of the status register always read 0, and a write to offset 2 changes nothing.
- R3: With the acknowledge bit set, an address byte whose bits 7:1 equal bits 7:1 of the address register and whose bit 0 (R/W) is 0 is answered with ACK (SDA low in the ninth clock), sets the flag and gives code 0x60. Any other non-general-call address byte, including the own address with R/W = 1, gets no ACK and leaves the flag clear.
- R4: The address byte 0x00 is answered with ACK and code 0x70 only when bit 0 of the address register is 1. Otherwise it is ignored.
- R5: While the acknowledge bit is 0, a matching address is not acknowledged and does not set the flag.
- R6: A data byte received while addressed lands in the data register with the first received bit in bit 7. With the acknowledge bit set it is ACKed and gives code 0x80 after an own-address match, or 0x90 after a general call.
- R7: A data byte received while addressed with the acknowledge bit at 0 is NACKed and gives 0x88 (own address) or 0x98 (general call). After that, bytes and STOP are ignored, with no ACK and no flag, until the next START.
- R8: A STOP or a repeated START while addressed sets the flag with code 0xA0. A STOP seen with SCL high leaves SCL undriven.
- R9: While the flag is set, the block holds SCL low from its low phase onward. It releases SCL within two clock cycles after the flag clears.
- R10: The flag is cleared only by writing a 1 to bit 3 at offset 1, and the status then returns to 0xF8. Writing bit 3 at offset 0 does not set it. Status 0xF8 is shown exactly when the flag is clear.
- R11: The acknowledge bit is bit 2 of the control register. Writing 1 to bit 2 at offset 0 sets it, and writing 1 to bit 2 at offset 1 clears it.
- R12: The data register accepts processor writes only while the flag is set. It holds its value while the flag is set unless the processor writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_sel` |
| irq | output | 1 | Interrupt flag |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | Pull bus clock low when 1 |
| sda_oe | output | 1 | Pull bus data low when 1 |

## Verification
The address decoder is tried with all 256 possible first bytes, with general call enabled. This sweep separates exact 7-bit matches from near misses and from the read-direction variant of the own address, and it also catches the general-call case. Data bytes use all-zero, all-one, alternating and single-bit patterns, so a reversed shift order or a dropped bit is visible in the data register. Separate transfers switch the acknowledge bit off for an address and for a data byte, and switch general call off. These show that ACK, NACK and ignore are three distinct outcomes, and that the block stays silent after a NACK. Repeated START, STOP and a deliberately late flag clear show apart the 0xA0 event, clock stretching, and the no-drive case with SCL high.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    RA_SET  = 3'd0,
    RA_CLR  = 3'd1,
    RA_STAT = 3'd2,
    RA_DATA = 3'd3,
    RA_ADDR = 3'd4
  } reg_addr_e;

  localparam int unsigned CB_FLAG = 3;
  localparam int unsigned CB_ACK  = 2;

  // status code, upper five bits of the status byte
  typedef enum logic [4:0] {
    SC_ADDR_ACK = 5'h0C,
    SC_GC_ACK   = 5'h0E,
    SC_DAT_ACK  = 5'h10,
    SC_DAT_NAK  = 5'h11,
    SC_GCD_ACK  = 5'h12,
    SC_GCD_NAK  = 5'h13,
    SC_STOP     = 5'h14,
    SC_IDLE     = 5'h1F
  } stat_code_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHIFT,
    PH_DECIDE,
    PH_ACK,
    PH_WAIT
  } phase_e;

endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  // idle bus level is high, so stages come out of reset at 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_srx_cond.sv
module i2c_srx_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s_i;
      sda_d_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_d_q;
  assign scl_fall_o = ~scl_s_i & scl_d_q;
  assign start_o    = scl_s_i & scl_d_q & sda_d_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_d_q & ~sda_d_q & sda_s_i;

endmodule

// File: rtl/i2c_srx_fsm.sv
module i2c_srx_fsm
  import i2c_srx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-2:0] own_addr_i,
  input  logic          gc_en_i,
  input  logic          ack_en_i,
  output logic          ev_valid_o,
  output stat_code_e    ev_code_o,
  output logic          ev_load_o,
  output logic [DW-1:0] ev_byte_o,
  output logic          sda_oe_o
);

  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  phase_e        phase_q, phase_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] shreg_q, shreg_n;
  logic          addr_ph_q, addr_ph_n;
  logic          addressed_q, addressed_n;
  logic          gc_q, gc_n;
  logic          nak_q, nak_n;
  logic          sda_oe_q, sda_oe_n;
  stat_code_e    pend_q, pend_n;
  logic          own_hit, gc_hit, active;

  always_comb begin
    phase_n     = phase_q;
    cnt_n       = cnt_q;
    shreg_n     = shreg_q;
    addr_ph_n   = addr_ph_q;
    addressed_n = addressed_q;
    gc_n        = gc_q;
    nak_n       = nak_q;
    sda_oe_n    = sda_oe_q;
    pend_n      = pend_q;
    ev_valid_o  = 1'b0;
    ev_code_o   = SC_IDLE;
    ev_load_o   = 1'b0;
    own_hit     = (shreg_q[DW-1:1] == own_addr_i) && !shreg_q[0];
    gc_hit      = (shreg_q == '0) && gc_en_i;
    active      = addressed_q &&
                  ((phase_q == PH_SHIFT) || (phase_q == PH_DECIDE) || (phase_q == PH_ACK));

    if (start_i) begin
      if (active) begin
        ev_valid_o = 1'b1;
        ev_code_o  = SC_STOP;
      end
      phase_n     = PH_SHIFT;
      cnt_n       = '0;
      addr_ph_n   = 1'b1;
      addressed_n = 1'b0;
      gc_n        = 1'b0;
      nak_n       = 1'b0;
      sda_oe_n    = 1'b0;
    end else if (stop_i) begin
      if (active) begin
        ev_valid_o = 1'b1;
        ev_code_o  = SC_STOP;
      end
      phase_n     = PH_IDLE;
      addressed_n = 1'b0;
      sda_oe_n    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_SHIFT: begin
          if (scl_rise_i) begin
            shreg_n = {shreg_q[DW-2:0], sda_s_i};
            if (cnt_q == LAST_BIT) phase_n = PH_DECIDE;
            else                   cnt_n   = cnt_q + 1'b1;
          end
        end
        PH_DECIDE: begin
          if (scl_fall_i) begin
            if (addr_ph_q) begin
              if ((own_hit || gc_hit) && ack_en_i) begin
                sda_oe_n    = 1'b1;
                phase_n     = PH_ACK;
                addressed_n = 1'b1;
                gc_n        = gc_hit;
                nak_n       = 1'b0;
                pend_n      = gc_hit ? SC_GC_ACK : SC_ADDR_ACK;
              end else begin
                phase_n     = PH_WAIT;
                addressed_n = 1'b0;
              end
            end else begin
              sda_oe_n = ack_en_i;
              nak_n    = !ack_en_i;
              phase_n  = PH_ACK;
              if (gc_q) pend_n = ack_en_i ? SC_GCD_ACK : SC_GCD_NAK;
              else      pend_n = ack_en_i ? SC_DAT_ACK : SC_DAT_NAK;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall_i) begin
            sda_oe_n   = 1'b0;
            ev_valid_o = 1'b1;
            ev_code_o  = pend_q;
            ev_load_o  = 1'b1;
            cnt_n      = '0;
            addr_ph_n  = 1'b0;
            if (nak_q) begin
              phase_n     = PH_WAIT;
              addressed_n = 1'b0;
            end else begin
              phase_n     = PH_SHIFT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      shreg_q     <= '0;
      addr_ph_q   <= 1'b1;
      addressed_q <= 1'b0;
      gc_q        <= 1'b0;
      nak_q       <= 1'b0;
      sda_oe_q    <= 1'b0;
      pend_q      <= SC_IDLE;
    end else begin
      phase_q     <= phase_n;
      cnt_q       <= cnt_n;
      shreg_q     <= shreg_n;
      addr_ph_q   <= addr_ph_n;
      addressed_q <= addressed_n;
      gc_q        <= gc_n;
      nak_q       <= nak_n;
      sda_oe_q    <= sda_oe_n;
      pend_q      <= pend_n;
    end
  end

  assign ev_byte_o = shreg_q;
  assign sda_oe_o  = sda_oe_q;

endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
  import i2c_srx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             ev_valid_i,
  input  stat_code_e       ev_code_i,
  input  logic             ev_load_i,
  input  logic [DW-1:0]    ev_byte_i,
  output logic             flag_o,
  output logic             ack_en_o,
  output logic [DW-2:0]    own_addr_o,
  output logic             gc_en_o,
  output logic [DW-1:0]    dat_o
);

  logic          flag_q, flag_n;
  logic          ack_q, ack_n;
  stat_code_e    stat_q, stat_n;
  logic [DW-1:0] dat_q, dat_n;
  logic [DW-1:0] addr_q, addr_n;
  logic          wr_set, wr_clr, wr_dat, wr_adr;

  assign wr_set = bus_wr && (bus_sel == RA_SET);
  assign wr_clr = bus_wr && (bus_sel == RA_CLR);
  assign wr_dat = bus_wr && (bus_sel == RA_DATA);
  assign wr_adr = bus_wr && (bus_sel == RA_ADDR);

  always_comb begin
    flag_n = flag_q;
    stat_n = stat_q;
    ack_n  = ack_q;
    dat_n  = dat_q;
    addr_n = addr_q;
    if (wr_clr && bus_wdata[CB_FLAG]) begin
      flag_n = 1'b0;
      stat_n = SC_IDLE;
    end
    if (ev_valid_i) begin
      flag_n = 1'b1;
      stat_n = ev_code_i;
    end
    if (wr_set && bus_wdata[CB_ACK]) ack_n = 1'b1;
    if (wr_clr && bus_wdata[CB_ACK]) ack_n = 1'b0;
    if (wr_dat && flag_q)            dat_n = bus_wdata;
    if (ev_load_i)                   dat_n = ev_byte_i;
    if (wr_adr)                      addr_n = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ack_q  <= 1'b0;
      stat_q <= SC_IDLE;
      dat_q  <= '0;
      addr_q <= '0;
    end else begin
      flag_q <= flag_n;
      ack_q  <= ack_n;
      stat_q <= stat_n;
      dat_q  <= dat_n;
      addr_q <= addr_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      RA_SET: begin
        bus_rdata[CB_FLAG] = flag_q;
        bus_rdata[CB_ACK]  = ack_q;
      end
      RA_STAT: bus_rdata = DW'({stat_q, 3'b000});
      RA_DATA: bus_rdata = dat_q;
      RA_ADDR: bus_rdata = addr_q;
      default: bus_rdata = '0;
    endcase
  end

  assign flag_o     = flag_q;
  assign ack_en_o   = ack_q;
  assign own_addr_o = addr_q[DW-1:1];
  assign gc_en_o    = addr_q[0];
  assign dat_o      = dat_q;

endmodule

// File: rtl/i2c_srx_top.sv
module i2c_srx_top
  import i2c_srx_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);

  logic          scl_s, sda_s;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic          ev_valid, ev_load;
  stat_code_e    ev_code;
  logic [DW-1:0] ev_byte;
  logic          flag, ack_en, gc_en;
  logic [DW-2:0] own_addr;
  logic [DW-1:0] dat_q;

  i2c_srx_sync #(.WIDTH(2), .STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_srx_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_srx_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .own_addr_i (own_addr),
    .gc_en_i    (gc_en),
    .ack_en_i   (ack_en),
    .ev_valid_o (ev_valid),
    .ev_code_o  (ev_code),
    .ev_load_o  (ev_load),
    .ev_byte_o  (ev_byte),
    .sda_oe_o   (sda_oe)
  );

  i2c_srx_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ev_valid_i (ev_valid),
    .ev_code_i  (ev_code),
    .ev_load_i  (ev_load),
    .ev_byte_i  (ev_byte),
    .flag_o     (flag),
    .ack_en_o   (ack_en),
    .own_addr_o (own_addr),
    .gc_en_o    (gc_en),
    .dat_o      (dat_q)
  );

  // stretch only from the low phase: a high clock is left alone
  assign scl_oe = flag & ~scl_s;
  assign irq    = flag;

endmodule

// File: rtl/i2c_srx_chk.sv
module i2c_srx_chk
  import i2c_srx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] bus_sel,
  input logic             bus_wr,
  input logic             clr_bit,
  input logic [7:0]       bus_rdata,
  input logic             irq,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic [7:0]       dat_q
);

  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == RA_STAT) |-> (bus_rdata[2:0] == 3'b000)); // R2

  AST_IDLE_CODE_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == RA_STAT && !irq) |-> (bus_rdata == 8'hF8)); // R10

  AST_FLAG_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == RA_STAT && irq) |-> (bus_rdata != 8'hF8)); // R10

  AST_FLAG_CLR_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr && bus_sel == RA_CLR && clr_bit)); // R10

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_oe) && irq) |-> scl_oe); // R9

  AST_NO_ACK_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !irq); // R6

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && irq && !$past(bus_wr && bus_sel == RA_DATA)) |-> $stable(dat_q)); // R12

endmodule

bind i2c_srx_top i2c_srx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .clr_bit   (bus_wdata[3]),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .dat_q     (dat_q)
);

// File: tb/i2c_srx_top_tb_top.sv
module i2c_srx_top_tb_top;
  import i2c_srx_pkg::*;

  localparam int Q = 6;
  localparam logic [7:0] OWN_REG = 8'h53;   // own 7-bit 0x29, general call on
  localparam logic [7:0] OWN_WR  = 8'h52;

  logic       clk;
  logic       rst_n;
  logic [2:0] bus_sel;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       m_scl_low, m_sda_low;
  logic       scl_bus, sda_bus;
  int         n_chk, n_fail;

  assign scl_bus = ~(m_scl_low | scl_oe);
  assign sda_bus = ~(m_sda_low | sda_oe);

  i2c_srx_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .scl_i     (scl_bus),
    .sda_i     (sda_bus),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel;
    #1 d = bus_rdata;
  endtask

  task automatic expect_evt(input string req, input logic f, input logic [7:0] code);
    logic [7:0] s;
    reg_rd(RA_STAT, s);
    chk(req, "flag", 32'(irq), 32'(f));
    chk(req, "status", 32'(s), 32'(code));
  endtask

  task automatic clear_flag();
    reg_wr(RA_CLR, 8'h08);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; wcyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    m_sda_low = 1'b1; wcyc(Q);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wcyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    m_sda_low = 1'b0; wcyc(Q);
  endtask

  task automatic m_bit(input logic b, input logic stretch_chk);
    m_sda_low = ~b; wcyc(Q);
    m_scl_low = 1'b0;
    if (stretch_chk) begin
      wcyc(20);
      chk("R9", "scl held", 32'(scl_bus), 32'd0);
      chk("R9", "flag during hold", 32'(irq), 32'd1);
      clear_flag();
      wcyc(2);
      chk("R9", "scl released", 32'(scl_bus), 32'd1);
    end
    wait_scl_high(); wcyc(Q);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic m_byte(input logic [7:0] b, input logic stretch_first, output logic acked);
    for (int i = 7; i >= 0; i--) m_bit(b[i], stretch_first && (i == 7));
    m_sda_low = 1'b0; wcyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); wcyc(2);
    acked = ~sda_bus;
    wcyc(Q);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       ack;
    logic [7:0] pats [7];
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_sel = '0; bus_wr = 1'b0; bus_wdata = '0;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};
    wcyc(5);
    rst_n = 1'b1;
    wcyc(3);

    // reset state (R1)
    reg_rd(RA_STAT, rd); chk("R1", "status", 32'(rd), 32'hF8);
    reg_rd(RA_SET,  rd); chk("R1", "control", 32'(rd), 32'h00);
    reg_rd(RA_DATA, rd); chk("R1", "data", 32'(rd), 32'h00);
    chk("R1", "scl_oe", 32'(scl_oe), 32'd0);
    chk("R1", "sda_oe", 32'(sda_oe), 32'd0);
    chk("R1", "irq", 32'(irq), 32'd0);

    // status read-only (R2)
    reg_wr(RA_STAT, 8'h00);
    reg_rd(RA_STAT, rd); chk("R2", "status after write", 32'(rd), 32'hF8);

    // acknowledge bit control (R11), flag cannot be set by software (R10)
    reg_wr(RA_SET, 8'h04);
    reg_rd(RA_SET, rd); chk("R11", "ack set", 32'(rd), 32'h04);
    reg_wr(RA_CLR, 8'h04);
    reg_rd(RA_SET, rd); chk("R11", "ack cleared", 32'(rd), 32'h00);
    reg_rd(RA_CLR, rd); chk("R11", "clear reads zero", 32'(rd), 32'h00);
    reg_wr(RA_SET, 8'h08);
    chk("R10", "flag not settable", 32'(irq), 32'd0);
    reg_wr(RA_SET, 8'h04);
    reg_wr(RA_ADDR, OWN_REG);

    // sweep every first byte (R3, R4, R8)
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      logic       exp_ack;
      bb = 8'(b);
      exp_ack = ((bb[7:1] == OWN_REG[7:1]) && !bb[0]) || (bb == 8'h00);
      m_start();
      m_byte(bb, 1'b0, ack);
      chk((bb == 8'h00) ? "R4" : "R3", "addr ack", 32'(ack), 32'(exp_ack));
      if (exp_ack) begin
        expect_evt((bb == 8'h00) ? "R4" : "R3", 1'b1, (bb == 8'h00) ? 8'h70 : 8'h60);
        clear_flag();
        m_stop();
        expect_evt("R8", 1'b1, 8'hA0);
        chk("R8", "scl undriven at stop", 32'(scl_bus), 32'd1);
        clear_flag();
      end else begin
        expect_evt("R3", 1'b0, 8'hF8);
        m_stop();
        chk("R3", "no flag after stop", 32'(irq), 32'd0);
      end
    end

    // data patterns with stretch on each byte (R6, R9, R12)
    m_start();
    m_byte(OWN_WR, 1'b0, ack);
    chk("R3", "own ack", 32'(ack), 32'd1);
    for (int k = 0; k < 7; k++) begin
      m_byte(pats[k], 1'b1, ack);
      chk("R6", "data ack", 32'(ack), 32'd1);
      expect_evt("R6", 1'b1, 8'h80);
      reg_rd(RA_DATA, rd); chk("R6", "data byte", 32'(rd), 32'(pats[k]));
    end
    reg_wr(RA_DATA, 8'h99);
    reg_rd(RA_DATA, rd); chk("R12", "write while flag", 32'(rd), 32'h99);
    clear_flag();
    reg_wr(RA_DATA, 8'h11);
    reg_rd(RA_DATA, rd); chk("R12", "write without flag", 32'(rd), 32'h99);
    m_stop();
    expect_evt("R8", 1'b1, 8'hA0);
    clear_flag();

    // NACK on data, then silence until START (R7)
    m_start();
    m_byte(OWN_WR, 1'b0, ack); clear_flag();
    reg_wr(RA_CLR, 8'h04);
    m_byte(8'hC3, 1'b0, ack);
    chk("R7", "nack", 32'(ack), 32'd0);
    expect_evt("R7", 1'b1, 8'h88);
    reg_rd(RA_DATA, rd); chk("R7", "nacked byte", 32'(rd), 32'hC3);
    clear_flag();
    reg_wr(RA_SET, 8'h04);
    m_byte(8'h11, 1'b0, ack);
    chk("R7", "ignored byte ack", 32'(ack), 32'd0);
    expect_evt("R7", 1'b0, 8'hF8);
    m_stop();
    chk("R7", "no flag on stop", 32'(irq), 32'd0);

    // general call data (R4, R6, R7)
    m_start();
    m_byte(8'h00, 1'b0, ack); expect_evt("R4", 1'b1, 8'h70); clear_flag();
    m_byte(8'h44, 1'b0, ack);
    chk("R6", "gc data ack", 32'(ack), 32'd1);
    expect_evt("R6", 1'b1, 8'h90); clear_flag();
    reg_wr(RA_CLR, 8'h04);
    m_byte(8'h45, 1'b0, ack);
    chk("R7", "gc nack", 32'(ack), 32'd0);
    expect_evt("R7", 1'b1, 8'h98); clear_flag();
    reg_wr(RA_SET, 8'h04);
    m_stop();
    chk("R7", "gc stop after nack", 32'(irq), 32'd0);

    // general call disabled (R4)
    reg_wr(RA_ADDR, OWN_WR);
    m_start();
    m_byte(8'h00, 1'b0, ack);
    chk("R4", "gc off ack", 32'(ack), 32'd0);
    expect_evt("R4", 1'b0, 8'hF8);
    m_stop();

    // acknowledge bit off on address (R5)
    reg_wr(RA_CLR, 8'h04);
    m_start();
    m_byte(OWN_WR, 1'b0, ack);
    chk("R5", "addr ack with AA off", 32'(ack), 32'd0);
    expect_evt("R5", 1'b0, 8'hF8);
    m_stop();
    reg_wr(RA_SET, 8'h04);

    // repeated START while addressed (R8, R9)
    m_start();
    m_byte(OWN_WR, 1'b0, ack); clear_flag();
    m_byte(8'h77, 1'b0, ack); expect_evt("R6", 1'b1, 8'h80); clear_flag();
    m_start();
    expect_evt("R8", 1'b1, 8'hA0);
    m_byte(OWN_WR, 1'b1, ack);
    chk("R8", "addr after rstart", 32'(ack), 32'd1);
    expect_evt("R8", 1'b1, 8'h60);
    clear_flag();
    expect_evt("R10", 1'b0, 8'hF8);
    m_stop();
    expect_evt("R8", 1'b1, 8'hA0);
    clear_flag();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule